// File: doc/BRIEF.md
# Bus Master Retry Sequencer

This block runs single memory cycles as a bus master and recovers from a retry exception raised by the system. A request is captured together with its address, direction and write data. The sequencer then asks for the bus, drives address phase T1 and data phase T2, and finishes when any of three terminator inputs is seen in T2.

If the retry input is seen in T2, the cycle is abandoned. This holds even when a terminator arrives at the same time. The bus is released for one hold cycle and a sticky pending flag is set. The same captured cycle is then run again. In immediate mode the bus is requested again right after the hold cycle. In latched mode the bus is not requested until software has cleared the pending flag and the retry input reads low.

The retry input is sampled either directly at the T2 clock edge or through a synchronizer chain. The synchronizer is used only when both the asynchronous-sampling bit and the asynchronous-bus bit are set. Otherwise the direct path is forced.

Top module: `busm_retry_seq`

## Requirements
- R1: While reset is asserted, bus_req, bus_own, cyc_done and retry_pending are all 0.
- R2: A pulse on cyc_req in idle raises bus_req on the next cycle. With bus_grant high, T1 follows, where bus_own and mem_strobe are 1 and mem_addr/mem_we/mem_wdata show the captured request. T2 follows T1. Any of term_ack, term_sterm or term_rdy in T2 ends the cycle, and cyc_done is a one-cycle pulse in the next cycle with bus_own back at 0. For a read (mem_we 0), cyc_rdata then holds mem_rdata from the terminating edge.
- R3: With no terminator and no retry, the sequencer stays in T2 (wait states) with bus_own held at 1.
- R4: A retry seen in T2 wins over any terminator. In the next cycle bus_own and bus_req are 0 and cyc_done stays 0.
- R5: With cfg_latched at 0, bus_req rises in the cycle after the hold cycle. The re-run T1 presents the same address, direction and write data as the aborted cycle.
- R6: With cfg_latched at 1, bus_req stays 0 after a retry while retry_pending is 1 or the sampled retry is 1. It rises in the cycle after both have dropped.
- R7: retry_pending becomes 1 in the hold cycle after every accepted retry. A one-cycle sts_clr pulse clears it on the next cycle when no retry is being accepted, and an accepted retry wins over a clear in the same cycle.
- R8: In direct sampling mode only the retry level at the T2 decision edge counts. A retry held high during T1 and dropped before that edge has no effect.
- R9: With cfg_async_sample and cfg_async_bus both at 1, retry passes through a two-flop synchronizer. A retry present at one T2 edge aborts the cycle two edges later, not earlier.
- R10: With cfg_async_sample at 1 and cfg_async_bus at 0, sampling is forced to the direct mode of R8.
- R11: An aborted read commits no data. cyc_rdata keeps its previous value and no cyc_done is given for the aborted attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_latched | input | 1 | 1: re-request waits for software clear |
| cfg_async_sample | input | 1 | 1: asks for synchronized retry sampling |
| cfg_async_bus | input | 1 | 1: bus interface runs in asynchronous mode |
| cyc_req | input | 1 | Request pulse for one memory cycle |
| cyc_addr | input | AW | Request address |
| cyc_we | input | 1 | Request direction, 1 = write |
| cyc_wdata | input | DW | Request write data |
| cyc_done | output | 1 | One-cycle completion pulse |
| cyc_rdata | output | DW | Data of the last completed read |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| bus_own | output | 1 | Grant acknowledge, high in T1 and T2 |
| mem_strobe | output | 1 | Memory cycle active |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory direction |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| term_ack | input | 1 | Data acknowledge terminator |
| term_sterm | input | 1 | Synchronous terminate |
| term_rdy | input | 1 | Ready terminator |
| retry_in | input | 1 | Retry exception input |
| retry_pending | output | 1 | Sticky retry status |
| sts_clr | input | 1 | Write-one-to-clear pulse for retry_pending |

## Verification
Each stimulus is applied just after a rising edge, and each result is read one full edge later, once the registered state has moved. bus_req is due one edge after a request or after the hold cycle. T1 follows grant by one edge, and cyc_done and cyc_rdata follow the terminating T2 edge by one. A retry aborts at the same T2 edge in direct mode and two edges later through the synchronizer. The async test therefore checks bus_own after each of the two intermediate edges. The pending flag is read one edge after acceptance or clear.

// File: rtl/busm_retry_pkg.sv
package busm_retry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_T1   = 3'd2,
    ST_T2   = 3'd3,
    ST_TH   = 3'd4,
    ST_LOCK = 3'd5
  } seq_state_e;
endpackage

// File: rtl/busm_retry_sampler.sv
module busm_retry_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_en,
  input  logic retry_in,
  output logic retry_seen
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  // Stage 0 captures the raw input; later stages shift it along.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= retry_in;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign retry_seen = async_en ? chain_q[LAST] : retry_in;
endmodule

// File: rtl/busm_retry_fsm.sv
module busm_retry_fsm
  import busm_retry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_req,
  input  logic bus_grant,
  input  logic term_any,
  input  logic retry_seen,
  input  logic latched,
  input  logic pending,
  output logic accept,
  output logic finish,
  output logic abort,
  output logic bus_req,
  output logic bus_own
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    finish  = 1'b0;
    abort   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cyc_req) begin
          accept  = 1'b1;
          state_d = ST_REQ;
        end
      end
      ST_REQ:  if (bus_grant) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2: begin
        // Retry is checked first so it beats every terminator.
        if (retry_seen) begin
          abort   = 1'b1;
          state_d = ST_TH;
        end else if (term_any) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_TH:   state_d = latched ? ST_LOCK : ST_REQ;
      ST_LOCK: if (!pending && !retry_seen) state_d = ST_REQ;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign bus_req = (state_q == ST_REQ);
  assign bus_own = (state_q == ST_T1) || (state_q == ST_T2);
endmodule

// File: rtl/busm_retry_status.sv
module busm_retry_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic pending
);
  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_en = set_evt || clr_evt;
    pend_d  = set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pending = pend_q;
endmodule

// File: rtl/busm_retry_regs.sv
module busm_retry_regs #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          finish,
  input  logic [AW-1:0] in_addr,
  input  logic          in_we,
  input  logic [DW-1:0] in_wdata,
  input  logic [DW-1:0] rd_bus,
  output logic [AW-1:0] out_addr,
  output logic          out_we,
  output logic [DW-1:0] out_wdata,
  output logic [DW-1:0] out_rdata,
  output logic          done
);
  logic [AW-1:0] addr_q;
  logic          we_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          done_q;
  logic          rd_en;

  assign rd_en = finish && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= in_addr;
      we_q    <= in_we;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end

  assign out_addr  = addr_q;
  assign out_we    = we_q;
  assign out_wdata = wdata_q;
  assign out_rdata = rdata_q;
  assign done      = done_q;
endmodule

// File: rtl/busm_retry_seq.sv
module busm_retry_seq #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_latched,
  input  logic          cfg_async_sample,
  input  logic          cfg_async_bus,
  input  logic          cyc_req,
  input  logic [AW-1:0] cyc_addr,
  input  logic          cyc_we,
  input  logic [DW-1:0] cyc_wdata,
  output logic          cyc_done,
  output logic [DW-1:0] cyc_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          bus_own,
  output logic          mem_strobe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          term_ack,
  input  logic          term_sterm,
  input  logic          term_rdy,
  input  logic          retry_in,
  output logic          retry_pending,
  input  logic          sts_clr
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;
  logic       async_en, retry_seen, term_any;
  logic       accept, finish, abort;

  // Reset asserts at once and is released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  // Synchronized sampling is only legal on an asynchronous bus.
  assign async_en = cfg_async_sample && cfg_async_bus;
  assign term_any = term_ack || term_sterm || term_rdy;

  busm_retry_sampler #(.STAGES(SYNC_STAGES)) samp_i (
    .clk(clk), .rst_n(rst_n_s), .async_en(async_en),
    .retry_in(retry_in), .retry_seen(retry_seen)
  );

  busm_retry_fsm fsm_i (
    .clk(clk), .rst_n(rst_n_s), .cyc_req(cyc_req), .bus_grant(bus_grant),
    .term_any(term_any), .retry_seen(retry_seen), .latched(cfg_latched),
    .pending(retry_pending), .accept(accept), .finish(finish),
    .abort(abort), .bus_req(bus_req), .bus_own(bus_own)
  );

  busm_retry_status sts_i (
    .clk(clk), .rst_n(rst_n_s), .set_evt(abort), .clr_evt(sts_clr),
    .pending(retry_pending)
  );

  busm_retry_regs #(.AW(AW), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n_s), .accept(accept), .finish(finish),
    .in_addr(cyc_addr), .in_we(cyc_we), .in_wdata(cyc_wdata),
    .rd_bus(mem_rdata), .out_addr(mem_addr), .out_we(mem_we),
    .out_wdata(mem_wdata), .out_rdata(cyc_rdata), .done(cyc_done)
  );

  assign mem_strobe = bus_own;
endmodule

// File: rtl/busm_retry_chk.sv
module busm_retry_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_own,
  input logic          cyc_done,
  input logic          retry_pending,
  input logic          sts_clr,
  input logic          cfg_latched,
  input logic [AW-1:0] mem_addr
);
  // R2: request and ownership never overlap.
  p_req_own_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_own));

  // R2: completion only follows a cycle that owned the bus.
  p_done_after_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> $past(bus_own));

  // R2: completion is a single-cycle pulse.
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done);

  // R4: an accepted retry leaves the bus released and no completion.
  p_retry_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_pending) |-> (!bus_own && !bus_req && !cyc_done));

  // R5: address is steady for the whole owned cycle.
  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_own && $past(bus_own)) |-> $stable(mem_addr));

  // R6: latched mode never requests while status is pending.
  p_latched_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latched && retry_pending) |-> !bus_req);

  // R7: a clear outside an owned cycle drops the status next cycle.
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !bus_own) |=> !retry_pending);
endmodule

bind busm_retry_seq busm_retry_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_own(bus_own),
  .cyc_done(cyc_done), .retry_pending(retry_pending), .sts_clr(sts_clr),
  .cfg_latched(cfg_latched), .mem_addr(mem_addr)
);

// File: tb/busm_retry_seq_tb_top.sv
`timescale 1ns/100ps
module busm_retry_seq_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_latched = 1'b0, cfg_async_sample = 1'b0, cfg_async_bus = 1'b0;
  logic cyc_req = 1'b0, cyc_we = 1'b0;
  logic [AW-1:0] cyc_addr = '0;
  logic [DW-1:0] cyc_wdata = '0, mem_rdata = '0;
  logic bus_grant = 1'b1;
  logic term_ack = 1'b0, term_sterm = 1'b0, term_rdy = 1'b0;
  logic retry_in = 1'b0, sts_clr = 1'b0;
  logic cyc_done, bus_req, bus_own, mem_strobe, mem_we, retry_pending;
  logic [DW-1:0] cyc_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  busm_retry_seq #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_latched(cfg_latched),
    .cfg_async_sample(cfg_async_sample), .cfg_async_bus(cfg_async_bus),
    .cyc_req(cyc_req), .cyc_addr(cyc_addr), .cyc_we(cyc_we),
    .cyc_wdata(cyc_wdata), .cyc_done(cyc_done), .cyc_rdata(cyc_rdata),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_own(bus_own),
    .mem_strobe(mem_strobe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .term_ack(term_ack),
    .term_sterm(term_sterm), .term_rdy(term_rdy), .retry_in(retry_in),
    .retry_pending(retry_pending), .sts_clr(sts_clr)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Issue a request and walk to T2; checks R2 on the way.
  task automatic to_t2(input logic [AW-1:0] a, input logic we, input logic [DW-1:0] wd);
    cyc_addr = a; cyc_we = we; cyc_wdata = wd; cyc_req = 1'b1;
    step();
    cyc_req = 1'b0;
    chk("R2 bus_req after request", bus_req, 1);
    step();
    chk("R2 T1 bus_own", bus_own, 1);
    chk("R2 T1 strobe", mem_strobe, 1);
    chk("R2 T1 addr", mem_addr, a);
    chk("R2 T1 dir", mem_we, we);
    step();
  endtask

  // From hold cycle: re-request, re-run and finish (non-latched).
  task automatic rerun(input string tag, input logic [AW-1:0] a, input logic we,
                       input logic [DW-1:0] wd, input logic [DW-1:0] rd);
    step();
    chk({tag, " re-request"}, bus_req, 1);
    step();
    chk({tag, " re-run addr"}, mem_addr, a);
    chk({tag, " re-run dir"}, mem_we, we);
    chk({tag, " re-run wdata"}, mem_wdata, wd);
    step();
    mem_rdata = rd; term_ack = 1'b1;
    step();
    term_ack = 1'b0;
    chk({tag, " re-run done"}, cyc_done, 1);
    if (!we) chk({tag, " re-run rdata"}, cyc_rdata, rd);
  endtask

  task automatic clear_status();
    sts_clr = 1'b1;
    step();
    sts_clr = 1'b0;
    chk("R7 clear drops pending", retry_pending, 0);
  endtask

  task automatic t_reset();
    chk("R1 bus_req", bus_req, 0);
    chk("R1 bus_own", bus_own, 0);
    chk("R1 done", cyc_done, 0);
    chk("R1 pending", retry_pending, 0);
  endtask

  task automatic t_read(input int which, input logic [DW-1:0] d);
    to_t2(32'h1000 + which, 1'b0, '0);
    step();  // wait state
    chk("R3 wait state holds bus", bus_own, 1);
    mem_rdata = d;
    case (which)
      0: term_ack = 1'b1;
      1: term_sterm = 1'b1;
      default: term_rdy = 1'b1;
    endcase
    step();
    term_ack = 1'b0; term_sterm = 1'b0; term_rdy = 1'b0;
    chk("R2 done pulse", cyc_done, 1);
    chk("R2 read data", cyc_rdata, d);
    chk("R2 bus released", bus_own, 0);
    step();
    chk("R2 done single cycle", cyc_done, 0);
  endtask

  task automatic t_write();
    to_t2(32'h2000, 1'b1, 32'hCAFE0001);
    chk("R2 write data", mem_wdata, 32'hCAFE0001);
    term_rdy = 1'b1;
    step();
    term_rdy = 1'b0;
    chk("R2 write done", cyc_done, 1);
    chk("R2 write keeps rdata", cyc_rdata, 32'h0000B002);
  endtask

  task automatic t_retry_immediate();
    to_t2(32'h3000, 1'b0, '0);
    retry_in = 1'b1; term_ack = 1'b1; mem_rdata = 32'hDEADDEAD;
    step();
    retry_in = 1'b0; term_ack = 1'b0;
    chk("R4 retry beats terminator: bus_own", bus_own, 0);
    chk("R4 no done on abort", cyc_done, 0);
    chk("R7 pending set", retry_pending, 1);
    chk("R11 no partial read", cyc_rdata, 32'h0000B002);
    rerun("R5", 32'h3000, 1'b0, '0, 32'h5555AAAA);
    clear_status();
  endtask

  task automatic t_retry_latched();
    cfg_latched = 1'b1;
    to_t2(32'h4000, 1'b1, 32'h77778888);
    retry_in = 1'b1;
    step();
    chk("R4 latched abort releases", bus_own, 0);
    chk("R7 pending set latched", retry_pending, 1);
    step();
    chk("R6 blocked while pending", bus_req, 0);
    step();
    chk("R6 still blocked", bus_req, 0);
    sts_clr = 1'b1;
    step();
    sts_clr = 1'b0;
    chk("R7 cleared in lock", retry_pending, 0);
    chk("R6 blocked while retry high", bus_req, 0);
    step();
    chk("R6 blocked retry still high", bus_req, 0);
    retry_in = 1'b0;
    step();
    chk("R6 re-request after release", bus_req, 1);
    step();
    chk("R6 re-run addr", mem_addr, 32'h4000);
    chk("R6 re-run wdata", mem_wdata, 32'h77778888);
    step();
    term_sterm = 1'b1;
    step();
    term_sterm = 1'b0;
    chk("R6 re-run done", cyc_done, 1);
    cfg_latched = 1'b0;
  endtask

  task automatic t_sync_window();
    cyc_addr = 32'h5000; cyc_we = 1'b0; cyc_req = 1'b1;
    step();
    cyc_req = 1'b0;
    step();  // now T1
    retry_in = 1'b1;
    step();  // edge into T2 while retry high
    retry_in = 1'b0;
    step();  // T2 decision edge with retry low
    chk("R8 T1-only retry ignored", bus_own, 1);
    chk("R8 no pending", retry_pending, 0);
    mem_rdata = 32'h0BADF00D; term_rdy = 1'b1;
    step();
    term_rdy = 1'b0;
    chk("R8 normal completion", cyc_done, 1);
  endtask

  task automatic t_async(input logic bus_async);
    cfg_async_sample = 1'b1; cfg_async_bus = bus_async;
    step(); step(); step();
    to_t2(32'h6000, 1'b0, '0);
    retry_in = 1'b1;
    step();  // decision edge D
    retry_in = 1'b0;
    if (bus_async) begin
      chk("R9 not taken at D", bus_own, 1);
      step();
      chk("R9 not taken at D+1", bus_own, 1);
      step();
      chk("R9 taken at D+2", bus_own, 0);
      chk("R9 pending", retry_pending, 1);
      rerun("R9", 32'h6000, 1'b0, '0, 32'h12345678);
    end else begin
      chk("R10 forced direct: taken at D", bus_own, 0);
      chk("R10 pending", retry_pending, 1);
      rerun("R10", 32'h6000, 1'b0, '0, 32'h87654321);
    end
    clear_status();
    cfg_async_sample = 1'b0; cfg_async_bus = 1'b0;
    step(); step(); step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    t_reset();
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
    t_reset();
    t_read(0, 32'h0000A000);
    t_read(1, 32'h0000A001);
    t_read(2, 32'h0000B002);
    t_write();
    t_retry_immediate();
    t_read(2, 32'h0000B002);
    t_retry_latched();
    t_sync_window();
    t_read(2, 32'h0000B002);
    t_async(1'b1);
    t_async(1'b0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule